// File: doc/BRIEF.md
# Error-Correcting Memory Word Controller with Diagnostic Modes

This block sits between a 32-bit memory data bus and the memory's check-bit lane. On writes it produces seven check bits for the word held in its input register. On reads it compares stored check bits against freshly generated ones, flags single and multiple errors, and can repair a single flipped data bit before the word is captured in its output register. It uses a single-error-correcting, double-error-detecting code with odd-weight columns.

A diagnostic register, loaded from the data bus, lets test software inject known check bits in place of the generated or stored ones. It can also take over the control inputs entirely. Two further modes are decoded from the mode pins together with the correct input. Initialize clears the input data register. Passthrough copies the registers straight to the outputs without any checking. The 8-bit SC output carries check bits, the syndrome or the stored check bits, depending on the mode. Output drivers are modelled as data plus a per-lane valid flag.

Top module: `edc_mode_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), all registers are zero. In generate phase with enables low, this gives sc = 0, dout = 0, err_n = 1 and merr_n = 1.
- R2: Loading of data and check-bit registers:
  - At a rising clock edge with ld_in high, the data register takes din and the check-bit register takes cb_in.
  - With ld_in low, both registers hold their values.
- R3: Generate phase (ld_out_gen low):
  - sc = {1'b0, C}, where C[j] is the XOR of every data-register bit i whose column has bit j set.
  - The column of data bit i is the i-th 7-bit value, counting from 0, in ascending numeric order among the values with exactly three ones.
  - err_n and merr_n are 1.
  - dout holds its value.
- R4: Check phase (ld_out_gen high) in modes other than initialize and passthrough:
  - sc = {1'b0, S}, where S = C XOR (reference check bits[6:0]).
  - err_n is 0 exactly when S is nonzero.
  - merr_n is 0 when S is nonzero, does not equal any data column, and does not have exactly one bit set.
- R5: In check phase, dout takes the data register at the clock edge.
  - With effective correct high, the data bit whose column equals S is inverted first.
  - With effective correct low, the data passes unchanged.
- R6: dout_vld[k] is high exactly when byte_oe_n[k] is low. sc_vld is high exactly when sc_oe_n is low.
- R7: Mode 01 (diagnostic generate):
  - In generate phase, sc = diag[7:0].
  - Check phase behaves as in mode 00.
- R8: Mode 10 (diagnostic check):
  - In check phase, the reference check bits are diag[6:0] instead of the check-bit register.
  - Generate phase behaves as in mode 00.
- R9: Mode 11 with correct high (initialize):
  - At every clock edge the data register is cleared, even with ld_in high, and stays zero after the mode is left.
  - sc = 0 and both flags are 1.
  - In check phase dout loads zero.
- R10: Mode 11 with correct low (passthrough):
  - sc = the full 8-bit check-bit register, and both flags are 1.
  - In check phase, dout loads the data register uncorrected.
- R11: Internal control:
  - When code_id = 01, the mode comes from diag[11:10] and correct comes from diag[12]. The dmode and corr_en pins are then ignored.
  - diag[9:8] and diag[31:13] have no effect in any mode.
  - The diagnostic register loads din at a clock edge with ld_diag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 32 | Data bus into the data and diagnostic registers |
| cb_in | input | 8 | Check bits read from memory |
| ld_in | input | 1 | Load enable for data and check-bit registers |
| ld_diag | input | 1 | Load enable for the diagnostic register |
| ld_out_gen | input | 1 | Low: generate phase, output held. High: check phase, output loads |
| corr_en | input | 1 | Correct enable pin |
| dmode | input | 2 | Diagnostic mode pins |
| code_id | input | 2 | Code identifier; 01 selects internal control |
| byte_oe_n | input | 4 | Active-low output enables for the four data bytes |
| sc_oe_n | input | 1 | Active-low output enable for sc |
| dout | output | 32 | Output register contents |
| dout_vld | output | 4 | Per-byte drive flag for dout |
| sc | output | 8 | Check bits, syndrome or stored check bits |
| sc_vld | output | 1 | Drive flag for sc |
| err_n | output | 1 | Low when any error is seen |
| merr_n | output | 1 | Low when an uncorrectable error is seen |

## Verification
The data register can take a new word at the same edge at which the output register captures the corrected form of the previous word. Every vector of the table drives ld_in and ld_out_gen high together. The bench then compares dout one cycle later with its own corrected copy of the word loaded on the first edge, not the one present afterwards. A second overlap is a load request colliding with initialize. ld_in is held high with nonzero data during the initialize cycle, and generated check bits of zero afterwards show that clearing took precedence.

// File: rtl/edc_mode_pkg.sv
// Shared types and code-construction helpers for the error-correcting
// word controller. Assumes a 7-bit check field with at least as many
// weight-three columns as data bits (35 available).
package edc_mode_pkg;

    localparam int DW        = 32;
    localparam int CW        = 7;
    localparam int SCW       = 8;
    localparam int DG_MODE_LSB = 10;
    localparam int DG_CORR_BIT = 12;

    typedef enum logic [2:0] {
        MD_NORM,
        MD_DGEN,
        MD_DDET,
        MD_INIT,
        MD_PASS
    } edc_mode_e;

    // Return the idx-th weight-three 7-bit value in ascending order.
    function automatic logic [CW-1:0] col_of(input int idx);
        int cnt;
        logic [CW-1:0] res;
        cnt = 0;
        res = '0;
        for (int v = 0; v < (1 << CW); v++) begin
            if ($countones(v[CW-1:0]) == 3) begin
                if (cnt == idx) res = v[CW-1:0];
                cnt++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/edc_mode_decode.sv
// Resolves the effective operating mode and correct enable from either the
// external pins or, when code_id selects internal control, the diagnostic
// register fields. Purely combinational.
module edc_mode_decode
    import edc_mode_pkg::*;
#(
    parameter int DGW = 32
) (
    input  logic [1:0]     code_id,
    input  logic [1:0]     dmode,
    input  logic           corr_en,
    input  logic [DGW-1:0] diag_q,
    output edc_mode_e      mode,
    output logic           corr_eff
);

    localparam logic [1:0] INTERNAL_ID = 2'b01;

    logic [1:0] dm_eff;

    // Pick pin or register sourced control fields.
    always_comb begin
        if (code_id == INTERNAL_ID) begin
            dm_eff   = diag_q[DG_MODE_LSB +: 2];
            corr_eff = diag_q[DG_CORR_BIT];
        end else begin
            dm_eff   = dmode;
            corr_eff = corr_en;
        end
    end

    // Map the mode field and correct bit onto the mode enum.
    always_comb begin
        unique case (dm_eff)
            2'b00:   mode = MD_NORM;
            2'b01:   mode = MD_DGEN;
            2'b10:   mode = MD_DDET;
            default: mode = corr_eff ? MD_INIT : MD_PASS;
        endcase
    end

endmodule

// File: rtl/edc_secded.sv
// Odd-weight-column single-correct double-detect network: generates check
// bits, forms the syndrome against a reference and builds corrected data.
// Assumes DW <= 35 so every data bit owns a distinct weight-three column.
module edc_secded
    import edc_mode_pkg::*;
#(
    parameter int W  = 32,
    parameter int CB = 7
) (
    input  logic [W-1:0]  data,
    input  logic [CB-1:0] ref_cb,
    output logic [CB-1:0] gen_cb,
    output logic [CB-1:0] syn,
    output logic          any_err,
    output logic          multi_err,
    output logic [W-1:0]  fixed
);

    logic [W-1:0] hit;

    // Per-bit column match drives the flip vector.
    for (genvar i = 0; i < W; i++) begin : g_col
        localparam logic [CB-1:0] COL = col_of(i);
        assign hit[i] = (syn == COL);
    end

    // Fold data bits into check bits by column membership.
    always_comb begin
        gen_cb = '0;
        for (int i = 0; i < W; i++) begin
            gen_cb = gen_cb ^ ({CB{data[i]}} & col_of(i));
        end
    end

    // Syndrome, error classification and single-bit repair.
    always_comb begin
        syn       = gen_cb ^ ref_cb;
        any_err   = |syn;
        multi_err = any_err && ($countones(syn) != 1) && !(|hit);
        fixed     = data ^ hit;
    end

endmodule

// File: rtl/edc_latch_bank.sv
// Holds the data, check-bit, diagnostic and output registers. Each loads at
// the clock edge while its enable is high; clr_data overrides the data load.
module edc_latch_bank #(
    parameter int W   = 32,
    parameter int SW  = 8,
    parameter int DGW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_in,
    input  logic           ld_diag,
    input  logic           ld_out,
    input  logic           clr_data,
    input  logic [W-1:0]   din,
    input  logic [SW-1:0]  cb_in,
    input  logic [W-1:0]   out_next,
    output logic [W-1:0]   data_q,
    output logic [SW-1:0]  cb_q,
    output logic [DGW-1:0] diag_q,
    output logic [W-1:0]   out_q
);

    // Data register: clear wins over load.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_data) data_q <= '0;
        else if (ld_in)         data_q <= din;
    end

    // Stored check-bit register.
    always_ff @(posedge clk) begin
        if (!rst_n)     cb_q <= '0;
        else if (ld_in) cb_q <= cb_in;
    end

    // Diagnostic register, loaded from the data bus.
    always_ff @(posedge clk) begin
        if (!rst_n)       diag_q <= '0;
        else if (ld_diag) diag_q <= din[DGW-1:0];
    end

    // Output register, follows the check-phase result.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (ld_out) out_q <= out_next;
    end

endmodule

// File: rtl/edc_mode_ctrl.sv
// Top level of the error-correcting word controller: registers, mode decode,
// code network and output selection. Outputs are data plus valid flags.
module edc_mode_ctrl
    import edc_mode_pkg::*;
#(
    parameter int NBYTE = DW / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   din,
    input  logic [SCW-1:0]  cb_in,
    input  logic            ld_in,
    input  logic            ld_diag,
    input  logic            ld_out_gen,
    input  logic            corr_en,
    input  logic [1:0]      dmode,
    input  logic [1:0]      code_id,
    input  logic [NBYTE-1:0] byte_oe_n,
    input  logic            sc_oe_n,
    output logic [DW-1:0]   dout,
    output logic [NBYTE-1:0] dout_vld,
    output logic [SCW-1:0]  sc,
    output logic            sc_vld,
    output logic            err_n,
    output logic            merr_n
);

    localparam int PAD = SCW - CW;

    logic [DW-1:0]  data_q, out_next, fixed;
    logic [SCW-1:0] cb_q;
    logic [DW-1:0]  diag_q;
    logic [CW-1:0]  gen_cb, syn, ref_cb;
    logic           any_err, multi_err, corr_eff, chk_active;
    edc_mode_e      mode;

    edc_mode_decode #(.DGW(DW)) u_dec (
        .code_id (code_id),
        .dmode   (dmode),
        .corr_en (corr_en),
        .diag_q  (diag_q),
        .mode    (mode),
        .corr_eff(corr_eff)
    );

    edc_latch_bank #(.W(DW), .SW(SCW), .DGW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_in   (ld_in),
        .ld_diag (ld_diag),
        .ld_out  (ld_out_gen),
        .clr_data(mode == MD_INIT),
        .din     (din),
        .cb_in   (cb_in),
        .out_next(out_next),
        .data_q  (data_q),
        .cb_q    (cb_q),
        .diag_q  (diag_q),
        .out_q   (dout)
    );

    edc_secded #(.W(DW), .CB(CW)) u_code (
        .data     (data_q),
        .ref_cb   (ref_cb),
        .gen_cb   (gen_cb),
        .syn      (syn),
        .any_err  (any_err),
        .multi_err(multi_err),
        .fixed    (fixed)
    );

    // Reference check bits: diagnostic field in diagnostic-check mode.
    assign ref_cb = (mode == MD_DDET) ? diag_q[CW-1:0] : cb_q[CW-1:0];

    // Flags are live only in check phase of the three checking modes.
    assign chk_active = ld_out_gen && (mode != MD_INIT) && (mode != MD_PASS);

    // Select what the sc lane carries.
    always_comb begin
        unique case (mode)
            MD_PASS: sc = cb_q;
            MD_INIT: sc = '0;
            MD_DGEN: sc = ld_out_gen ? {{PAD{1'b0}}, syn} : diag_q[SCW-1:0];
            default: sc = ld_out_gen ? {{PAD{1'b0}}, syn} : {{PAD{1'b0}}, gen_cb};
        endcase
    end

    // Next output-register value per mode.
    always_comb begin
        unique case (mode)
            MD_PASS: out_next = data_q;
            MD_INIT: out_next = '0;
            default: out_next = corr_eff ? fixed : data_q;
        endcase
    end

    // Active-low error flags.
    assign err_n  = !(chk_active && any_err);
    assign merr_n = !(chk_active && multi_err);

    // Drive flags mirror the active-low enables.
    assign dout_vld = ~byte_oe_n;
    assign sc_vld   = ~sc_oe_n;

endmodule

// File: rtl/edc_mode_ctrl_chk.sv
// Temporal checks for edc_mode_ctrl, attached with bind. Observes ports and
// the data register only.
module edc_mode_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ld_in,
    input logic        ld_out_gen,
    input logic        corr_en,
    input logic [1:0]  dmode,
    input logic [1:0]  code_id,
    input logic [31:0] din,
    input logic [31:0] dout,
    input logic [31:0] data_q,
    input logic        err_n,
    input logic        merr_n
);

    p_gen_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_out_gen |-> (err_n && merr_n));

    p_gen_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_out_gen |=> $stable(dout));

    p_merr_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !merr_n |-> !err_n);

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_in && code_id == 2'b00 && dmode != 2'b11) |=> data_q == $past(din));

    p_init_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (code_id == 2'b00 && dmode == 2'b11 && corr_en) |=> data_q == '0);

    p_clean_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_out_gen && code_id == 2'b00 && dmode == 2'b00 && err_n)
        |=> dout == $past(data_q));

endmodule

bind edc_mode_ctrl edc_mode_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_in     (ld_in),
    .ld_out_gen(ld_out_gen),
    .corr_en   (corr_en),
    .dmode     (dmode),
    .code_id   (code_id),
    .din       (din),
    .dout      (dout),
    .data_q    (data_q),
    .err_n     (err_n),
    .merr_n    (merr_n)
);

// File: tb/sim_edc_mode_ctrl.sv
`timescale 1ns/1ps
module sim_edc_mode_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] din;
    logic [7:0]  cb_in;
    logic        ld_in, ld_diag, ld_out_gen, corr_en, sc_oe_n;
    logic [1:0]  dmode, code_id;
    logic [3:0]  byte_oe_n;
    logic [31:0] dout;
    logic [3:0]  dout_vld;
    logic [7:0]  sc;
    logic        sc_vld, err_n, merr_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    edc_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .cb_in(cb_in), .ld_in(ld_in),
        .ld_diag(ld_diag), .ld_out_gen(ld_out_gen), .corr_en(corr_en),
        .dmode(dmode), .code_id(code_id), .byte_oe_n(byte_oe_n),
        .sc_oe_n(sc_oe_n), .dout(dout), .dout_vld(dout_vld), .sc(sc),
        .sc_vld(sc_vld), .err_n(err_n), .merr_n(merr_n)
    );

    // Vector fields: {dmode[2], corr[1], check flip[7], data flip[32], data[32]}
    localparam logic [73:0] VEC [0:9] = '{
        {2'b00, 1'b1, 7'h00, 32'h0000_0000, 32'h1234_5678},
        {2'b00, 1'b1, 7'h00, 32'h0000_0020, 32'hCAFE_F00D},
        {2'b00, 1'b0, 7'h00, 32'h8000_0000, 32'h0F0F_0F0F},
        {2'b00, 1'b1, 7'h08, 32'h0000_0000, 32'hA5A5_5A5A},
        {2'b00, 1'b1, 7'h00, 32'h0001_0100, 32'h1357_9BDF},
        {2'b00, 1'b1, 7'h02, 32'h0000_4000, 32'h2468_ACE0},
        {2'b00, 1'b1, 7'h00, 32'h0700_0000, 32'hDEAD_BEEF},
        {2'b01, 1'b1, 7'h00, 32'h0004_0000, 32'h7777_1111},
        {2'b00, 1'b1, 7'h00, 32'h0000_0000, 32'hFFFF_FFFF},
        {2'b00, 1'b1, 7'h00, 32'h0000_0001, 32'h8421_8421}
    };

    function automatic logic [6:0] b_col(input int k);
        int cnt = 0;
        logic [6:0] r = '0;
        for (int v = 0; v < 128; v++) begin
            if ($countones(v[6:0]) == 3) begin
                if (cnt == k) r = v[6:0];
                cnt++;
            end
        end
        return r;
    endfunction

    function automatic logic [6:0] b_gen(input logic [31:0] d);
        logic [6:0] c = '0;
        for (int i = 0; i < 32; i++) if (d[i]) c ^= b_col(i);
        return c;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ld_in = 0; ld_diag = 0; ld_out_gen = 0; corr_en = 0;
        dmode = 2'b00; code_id = 2'b00;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] d, w, exp_out, prev;
        logic [6:0]  cbv, syn;
        bit          found, exp_merr;
        int          idx;

        rst_n = 0; idle(); din = '0; cb_in = '0; byte_oe_n = '0; sc_oe_n = 0;
        @(negedge clk);
        tick(); tick(); tick();
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sc", {24'h0, sc}, 32'h0);
        chk("R1 dout", dout, 32'h0);
        chk("R1 flags", {30'h0, err_n, merr_n}, 32'h3);
        chk("R1 vld", {28'h0, dout_vld}, 32'hF);

        // Table walk: R2 load, R4 flags and syndrome, R5 output, R7 check unaffected
        for (int v = 0; v < 10; v++) begin
            d   = VEC[v][31:0];
            w   = d ^ VEC[v][63:32];
            cbv = b_gen(d) ^ VEC[v][70:64];
            din = w; cb_in = {1'b0, cbv}; ld_in = 1; ld_out_gen = 1;
            corr_en = VEC[v][71]; dmode = VEC[v][73:72];
            tick();
            syn = b_gen(w) ^ cbv;
            found = 0; idx = 0;
            for (int i = 0; i < 32; i++) if (syn == b_col(i)) begin found = 1; idx = i; end
            exp_merr = (syn != 0) && ($countones(syn) != 1) && !found;
            exp_out  = (corr_en && found) ? (w ^ (32'h1 << idx)) : w;
            chk($sformatf("R4 syndrome v%0d", v), {24'h0, sc}, {25'h0, syn});
            chk($sformatf("R4 err_n v%0d", v), {31'h0, err_n}, {31'h0, !(syn != 0)});
            chk($sformatf("R4 merr_n v%0d", v), {31'h0, merr_n}, {31'h0, !exp_merr});
            ld_in = 0;
            tick();
            if (!exp_merr) chk($sformatf("R5 R2 dout v%0d", v), dout, exp_out);
        end
        idle();

        // R3 generate phase: check bits, flags forced, output held
        prev = dout;
        din = 32'h0BAD_C0DE; cb_in = 8'h7F; ld_in = 1;
        tick();
        ld_in = 0;
        chk("R3 gen sc", {24'h0, sc}, {25'h0, b_gen(32'h0BAD_C0DE)});
        chk("R3 flags high", {30'h0, err_n, merr_n}, 32'h3);
        tick();
        chk("R3 dout hold", dout, prev);
        // R2 hold with ld_in low
        din = 32'h1111_2222;
        tick();
        chk("R2 hold", {24'h0, sc}, {25'h0, b_gen(32'h0BAD_C0DE)});

        // R6 enables
        byte_oe_n = 4'b1010; sc_oe_n = 1;
        #1;
        chk("R6 dout_vld", {28'h0, dout_vld}, 32'h5);
        chk("R6 sc_vld", {31'h0, sc_vld}, 32'h0);
        byte_oe_n = '0; sc_oe_n = 0;

        // R7 diagnostic generate
        din = 32'h0000_00A5; ld_diag = 1;
        tick();
        ld_diag = 0; dmode = 2'b01;
        #1;
        chk("R7 diag gen sc", {24'h0, sc}, 32'hA5);
        d = 32'h3C3C_00FF;
        din = d; cb_in = {1'b0, b_gen(d)}; ld_in = 1; ld_out_gen = 1;
        tick();
        ld_in = 0;
        chk("R7 check normal sc", {24'h0, sc}, 32'h0);
        chk("R7 check normal err", {31'h0, err_n}, 32'h1);

        // R8 diagnostic check: reference from diag field
        d = 32'h5555_AAAA;
        idle();
        din = {24'h0, 1'b0, b_gen(d)}; ld_diag = 1;
        tick();
        ld_diag = 0;
        din = d; cb_in = 8'h00; ld_in = 1;
        tick();
        ld_in = 0; dmode = 2'b10; ld_out_gen = 1;
        #1;
        chk("R8 syndrome via diag", {24'h0, sc}, 32'h0);
        chk("R8 no error", {31'h0, err_n}, 32'h1);
        ld_out_gen = 0;
        #1;
        chk("R8 gen normal", {24'h0, sc}, {25'h0, b_gen(d)});

        // R9 initialize, with a competing load in the same cycle
        idle();
        din = 32'h0000_0040; ld_in = 1;
        tick();
        chk("R9 pre nonzero", {24'h0, sc}, {25'h0, b_gen(32'h40)});
        din = 32'hFFFF_0001; ld_in = 1; dmode = 2'b11; corr_en = 1; ld_out_gen = 1;
        tick();
        chk("R9 init sc", {24'h0, sc}, 32'h0);
        chk("R9 init flags", {30'h0, err_n, merr_n}, 32'h3);
        ld_in = 0;
        tick();
        chk("R9 init dout", dout, 32'h0);
        idle();
        #1;
        chk("R9 data stays zero", {24'h0, sc}, 32'h0);
        tick();
        chk("R9 data still zero", {24'h0, sc}, 32'h0);

        // R10 passthrough
        d = 32'h0000_0100;
        din = d; cb_in = 8'hC3; ld_in = 1;
        tick();
        ld_in = 0; dmode = 2'b11; corr_en = 0;
        #1;
        chk("R10 pass gen sc", {24'h0, sc}, 32'hC3);
        ld_out_gen = 1;
        #1;
        chk("R10 pass flags", {30'h0, err_n, merr_n}, 32'h3);
        tick();
        chk("R10 pass sc", {24'h0, sc}, 32'hC3);
        chk("R10 pass dout", dout, d);

        // R11 internal control: diag selects initialize, pins say normal
        idle();
        din = 32'hFFFF_E000 | (32'h1 << 12) | (32'h3 << 10) | (32'h3 << 8) | 32'h5A;
        ld_diag = 1;
        tick();
        ld_diag = 0;
        din = 32'h0000_0800; ld_in = 1;
        tick();
        ld_in = 0;
        chk("R11 pre", {24'h0, sc}, {25'h0, b_gen(32'h800)});
        code_id = 2'b01;
        tick();
        code_id = 2'b00;
        #1;
        chk("R11 diag init cleared", {24'h0, sc}, 32'h0);

        // R11 diag selects diagnostic generate; junk high bits ignored
        din = 32'hABCD_E000 | (32'h1 << 10) | (32'h2 << 8) | 32'h5A;
        ld_diag = 1;
        tick();
        ld_diag = 0; code_id = 2'b01; dmode = 2'b00;
        #1;
        chk("R11 diag gen sc", {24'h0, sc}, 32'h5A);

        // R11 pins ignored: pins request initialize, diag says normal
        din = 32'h0000_0300; ld_diag = 1; code_id = 2'b00;
        tick();
        ld_diag = 0;
        din = 32'h0000_0004; ld_in = 1;
        tick();
        ld_in = 0; code_id = 2'b01; dmode = 2'b11; corr_en = 1;
        tick();
        chk("R11 pins ignored", {24'h0, sc}, {25'h0, b_gen(32'h4)});

        finish_run();
    end

endmodule